// File: doc/BRIEF.md
# Debug Port Bulk Download Engine

This engine sits behind a debug port and fills system memory from a development tool with as little port traffic as possible. The tool sends a stream of tagged words. Command words switch the engine in and out of a download loop. Data words that arrive inside the loop each become one memory write. No instruction words cross the port for any stored word.

Before a run, the tool loads the address pointer with one word below the first destination. For each stored word the pointer first steps up by the word stride. The word is then written at the stepped address, and the pointer keeps that value for the next word. Each incoming word is captured in a holding register. That register drives the memory write bus until the memory acknowledges.

An end command does not stop the loop at once. The engine still takes one more data word, writes nothing for it, and only then returns to idle. This lets the tool close the run cleanly.

Top module: `dbg_bulk_loader`

## Requirements
- R1: After a synchronous active-high reset, the engine is idle (`loading` low), `ptr_rd` is zero, `err_sticky` is low, `mem_req` is low and `in_ready` is high.
- R2: While idle, a cycle with `ptr_wr_en` high loads `ptr_wr_val` into the pointer, and the value is visible on `ptr_rd` one cycle later.
- R3: An accepted command word (`in_is_cmd` = 1) whose low two bits equal 2'b01 moves the engine from idle into the loop, and `loading` goes high.
- R4: An accepted data word in the loop increases the pointer by STRIDE (4 by default). It then issues exactly one write with `mem_addr` equal to the increased pointer and `mem_wdata` equal to the word.
- R5: While a write waits for `mem_ack`, `mem_req`, `mem_addr` and `mem_wdata` stay unchanged and `in_ready` is low, so at most one write is outstanding. `mem_req` drops in the cycle after the acknowledge.
- R6: An accepted command with low bits 2'b10 in the loop does not leave `loading`. The next accepted data word causes no write, leaves the pointer unchanged, and returns the engine to idle.
- R7: Command codes 2'b00 and 2'b11, a start command in the loop, and an end command while idle change neither the mode nor the pointer.
- R8: A data word accepted while idle is dropped without a write and sets `err_sticky`. The flag stays set until reset.
- R9: `ptr_wr_en` outside idle has no effect on the pointer.
- R10: After a run of N stored words that began from preload value P, `ptr_rd` equals P + 4·N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine can take a word |
| in_is_cmd | input | 1 | 1 = command word, 0 = data word |
| in_word | input | DATA_W | Command code in low bits, or data |
| ptr_wr_en | input | 1 | Pointer preload strobe |
| ptr_wr_val | input | ADDR_W | Pointer preload value |
| ptr_rd | output | ADDR_W | Current pointer value |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory write acknowledge |
| loading | output | 1 | Engine is in the loop or waiting for the closing word |
| err_sticky | output | 1 | Data was seen while idle |

## Verification
The embedded properties assume that the memory side raises `mem_ack` only while `mem_req` is high, and for a single cycle per write. They also assume that the tool changes its input word only once a transfer completes. The bench honours both. Its acknowledge responder waits a chosen number of cycles after it sees a request, pulses the acknowledge once, and drops it on the next cycle. Its driver presents a word only when `in_ready` is already high, and withdraws it right after the accepting edge.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOP  = 2'd1,
      ST_DRAIN = 2'd2
   } dbl_state_e;

   localparam logic [1:0] CODE_START = 2'b01;
   localparam logic [1:0] CODE_STOP  = 2'b10;
endpackage

// File: rtl/dbl_cmd_decode.sv
module dbl_cmd_decode #(
   parameter int CMD_W = 2
) (
   input  logic             fire,
   input  logic             is_cmd,
   input  logic [CMD_W-1:0] code,
   output logic             start_hit,
   output logic             stop_hit,
   output logic             data_hit
);
   import dbl_pkg::*;

   if (CMD_W < 2) begin : g_bad_cmd_w
      $error("dbl_cmd_decode: CMD_W must be at least 2");
   end

   logic [CMD_W-1:0] start_code;
   logic [CMD_W-1:0] stop_code;

   if (CMD_W == 2) begin : g_exact
      assign start_code = CODE_START;
      assign stop_code  = CODE_STOP;
   end else begin : g_wide
      assign start_code = {{(CMD_W-2){1'b0}}, CODE_START};
      assign stop_code  = {{(CMD_W-2){1'b0}}, CODE_STOP};
   end

   always_comb begin
      start_hit = fire && is_cmd && (code == start_code);
      stop_hit  = fire && is_cmd && (code == stop_code);
      data_hit  = fire && !is_cmd;
   end
endmodule

// File: rtl/dbl_addr_ptr.sv
module dbl_addr_ptr #(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] ptr_next
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

   if (STRIDE <= 0) begin : g_bad_stride
      $error("dbl_addr_ptr: STRIDE must be positive");
   end
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
      $error("dbl_addr_ptr: ADDR_W out of range");
   end

   assign ptr_next = ptr + STEP_V;

   always_ff @(posedge clk) begin
      if (rst)          ptr <= '0;
      else if (step)    ptr <= ptr_next;
      else if (load_en) ptr <= load_val;
   end

   // R4: a stored word advances the pointer by exactly one stride
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
      step |=> ptr == $past(ptr) + STEP_V);
   // R9: with neither strobe the pointer holds
   assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!step && !load_en) |=> $stable(ptr));
endmodule

// File: rtl/dbl_wr_port.sv
module dbl_wr_port #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  logic [ADDR_W-1:0] launch_addr,
   input  logic [DATA_W-1:0] launch_data,
   input  logic              ack,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("dbl_wr_port: DATA_W too small");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req  <= 1'b0;
         addr <= '0;
         data <= '0;
      end else if (launch) begin
         req  <= 1'b1;
         addr <= launch_addr;
         data <= launch_data;
      end else if (ack) begin
         req  <= 1'b0;
      end
   end

   // R5: a pending write holds its bus until acknowledged
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (req && !ack) |=> (req && $stable(addr) && $stable(data)));
   // R5: never a second launch while one is outstanding
   assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (rst)
      launch |-> !req);
   // R5: request drops after the acknowledge
   assert_req_release_R5: assert property (@(posedge clk) disable iff (rst)
      (ack && !launch) |=> !req);
endmodule

// File: rtl/dbl_ctrl.sv
module dbl_ctrl (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_hit,
   input  logic                stop_hit,
   input  logic                data_hit,
   output dbl_pkg::dbl_state_e state,
   output logic                store,
   output logic                err
);
   import dbl_pkg::*;

   dbl_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start_hit) state_nx = ST_LOOP;
         ST_LOOP:  if (stop_hit)  state_nx = ST_DRAIN;
         ST_DRAIN: if (data_hit)  state_nx = ST_IDLE;
         default:                 state_nx = ST_IDLE;
      endcase
   end

   assign store = data_hit && (state == ST_LOOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         err   <= 1'b0;
      end else begin
         state <= state_nx;
         if (data_hit && state == ST_IDLE) err <= 1'b1;
      end
   end

   // R6: the closing word ends the drain
   assert_drain_exit_R6: assert property (@(posedge clk) disable iff (rst)
      (data_hit && state == ST_DRAIN) |=> state == ST_IDLE);
   // R8: the error flag never clears outside reset
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      err |=> err);
   // R3: the loop is only entered from idle
   assert_loop_entry_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DRAIN) |=> state != ST_LOOP);
endmodule

// File: rtl/dbg_bulk_loader.sv
module dbg_bulk_loader #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int STRIDE = 4,
   parameter int CMD_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_is_cmd,
   input  logic [DATA_W-1:0] in_word,
   input  logic              ptr_wr_en,
   input  logic [ADDR_W-1:0] ptr_wr_val,
   output logic [ADDR_W-1:0] ptr_rd,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   output logic              loading,
   output logic              err_sticky
);
   import dbl_pkg::*;

   if (CMD_W > DATA_W) begin : g_bad_widths
      $error("dbg_bulk_loader: CMD_W exceeds DATA_W");
   end

   logic              fire;
   logic              start_hit;
   logic              stop_hit;
   logic              data_hit;
   logic              store;
   logic              ptr_load;
   logic [ADDR_W-1:0] ptr_next;
   dbl_state_e        state;

   assign in_ready = !mem_req;
   assign fire     = in_valid && in_ready;
   assign loading  = (state != ST_IDLE);
   assign ptr_load = ptr_wr_en && (state == ST_IDLE);

   dbl_cmd_decode #(.CMD_W(CMD_W)) u_dec (
      .fire      (fire),
      .is_cmd    (in_is_cmd),
      .code      (in_word[CMD_W-1:0]),
      .start_hit (start_hit),
      .stop_hit  (stop_hit),
      .data_hit  (data_hit)
   );

   dbl_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start_hit (start_hit),
      .stop_hit  (stop_hit),
      .data_hit  (data_hit),
      .state     (state),
      .store     (store),
      .err       (err_sticky)
   );

   dbl_addr_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load_en  (ptr_load),
      .load_val (ptr_wr_val),
      .step     (store),
      .ptr      (ptr_rd),
      .ptr_next (ptr_next)
   );

   dbl_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk         (clk),
      .rst         (rst),
      .launch      (store),
      .launch_addr (ptr_next),
      .launch_data (in_word),
      .ack         (mem_ack),
      .req         (mem_req),
      .addr        (mem_addr),
      .data        (mem_wdata)
   );

   // R8: idle data raises the error flag
   assert_idle_data_err_R8: assert property (@(posedge clk) disable iff (rst)
      (fire && !in_is_cmd && !loading) |=> err_sticky);
   // R6: the discarded closing word makes no write
   assert_drain_no_write_R6: assert property (@(posedge clk) disable iff (rst)
      (fire && !in_is_cmd && state == ST_DRAIN) |=> (!mem_req && $stable(ptr_rd)));
   // R9: preload outside idle leaves the pointer alone
   assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (rst)
      (ptr_wr_en && loading && !fire) |=> $stable(ptr_rd));
   // R4: a stored word's address is the stepped pointer
   assert_addr_matches_ptr_R4: assert property (@(posedge clk) disable iff (rst)
      (fire && !in_is_cmd && state == ST_LOOP) |=> (mem_req && mem_addr == ptr_rd));
endmodule

// File: tb/dbg_bulk_loader_tb.sv
module dbg_bulk_loader_tb;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          in_is_cmd = 1'b0;
   logic [DW-1:0] in_word = '0;
   logic          ptr_wr_en = 1'b0;
   logic [AW-1:0] ptr_wr_val = '0;
   logic [AW-1:0] ptr_rd;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic          loading;
   logic          err_sticky;

   always #2.5 clk = ~clk;

   dbg_bulk_loader u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_is_cmd(in_is_cmd), .in_word(in_word), .ptr_wr_en(ptr_wr_en),
      .ptr_wr_val(ptr_wr_val), .ptr_rd(ptr_rd), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .loading(loading), .err_sticky(err_sticky)
   );

   int checks = 0;
   int fails  = 0;
   int ack_delay = 0;
   bit finished = 0;

   logic [AW-1:0] exp_addr_q[$];
   logic [DW-1:0] exp_data_q[$];
   int writes_seen = 0;

   // behavioural reference
   int            m_mode = 0;   // 0 idle, 1 loop, 2 closing
   logic [AW-1:0] m_ptr  = '0;
   bit            m_err  = 0;
   bit            m_pend = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (rst) begin
            m_mode = 0; m_ptr = '0; m_err = 0; m_pend = 0;
         end else begin
            bit acc;
            acc = in_valid && !m_pend;
            if (m_pend && mem_ack) m_pend = 0;
            if (ptr_wr_en && m_mode == 0) m_ptr = ptr_wr_val;
            if (acc) begin
               if (in_is_cmd) begin
                  if (m_mode == 0 && in_word[1:0] == 2'b01) m_mode = 1;
                  else if (m_mode == 1 && in_word[1:0] == 2'b10) m_mode = 2;
               end else if (m_mode == 0) begin
                  m_err = 1;
               end else if (m_mode == 1) begin
                  m_ptr  = m_ptr + 4;
                  m_pend = 1;
                  m_addr = m_ptr;
                  m_data = in_word;
               end else begin
                  m_mode = 0;
               end
            end
         end
      end
   end

   // per-cycle comparison against the reference
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && !finished) begin
            chk("R5 in_ready", in_ready, !m_pend);
            chk("R4 mem_req", mem_req, m_pend);
            if (m_pend) begin
               chk("R4 mem_addr", mem_addr, m_addr);
               chk("R4 mem_wdata", mem_wdata, m_data);
            end
            chk("R2 ptr_rd", ptr_rd, m_ptr);
            chk("R8 err_sticky", err_sticky, m_err);
            chk("R3 loading", loading, m_mode != 0);
         end
      end
   end

   // memory responder and write monitor
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
         end else if (mem_req) begin
            if (wait_cnt >= ack_delay) begin
               mem_ack = 1'b1;
               writes_seen++;
               if (exp_addr_q.size() == 0) begin
                  chk("R6 unexpected write", 64'(mem_addr), 64'hFFFF_FFFF_FFFF_FFFF);
               end else begin
                  chk("R4 write addr", mem_addr, exp_addr_q.pop_front());
                  chk("R4 write data", mem_wdata, exp_data_q.pop_front());
               end
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic send(input bit c, input logic [DW-1:0] w);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_is_cmd = c; in_word = w;
      @(negedge clk);
      in_valid = 1'b0; in_is_cmd = 1'b0; in_word = '0;
   endtask

   task automatic preload(input logic [AW-1:0] v);
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_val = v;
      @(negedge clk);
      ptr_wr_en = 1'b0;
   endtask

   task automatic store_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_addr_q.push_back(a);
      exp_data_q.push_back(d);
      send(1'b0, d);
   endtask

   task automatic wait_idle_bus();
      while (mem_req || mem_ack) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++; checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] base;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 loading after reset", loading, 0);
      chk("R1 ptr after reset", ptr_rd, 0);
      chk("R1 err after reset", err_sticky, 0);
      chk("R1 req after reset", mem_req, 0);
      chk("R1 ready after reset", in_ready, 1);

      base = 32'h0000_1000 - 4;
      preload(base);
      chk("R2 preload visible", ptr_rd, base);

      send(1'b0, 32'hDEAD_0001);
      chk("R8 idle data sets err", err_sticky, 1);
      chk("R8 idle data no write", mem_req, 0);

      send(1'b1, 32'h0);
      send(1'b1, 32'h3);
      send(1'b1, 32'h2);
      chk("R7 ignored codes keep idle", loading, 0);
      chk("R7 ignored codes keep ptr", ptr_rd, base);

      send(1'b1, 32'h1);
      chk("R3 start enters loop", loading, 1);
      preload(32'h5555_0000);
      chk("R9 preload ignored in loop", ptr_rd, base);
      send(1'b1, 32'h1);
      send(1'b1, 32'h3);
      chk("R7 start in loop ignored", loading, 1);

      for (int i = 0; i < 5; i++) begin
         ack_delay = i % 4;
         store_word(32'h1000 + 4 * i, 32'hA500_0000 + 32'h0101 * i);
      end
      send(1'b1, 32'h2);
      chk("R6 still loading after end", loading, 1);
      wait_idle_bus();
      send(1'b0, 32'hBAD0_BAD0);
      chk("R6 closing word returns idle", loading, 0);
      chk("R6 closing word no write", mem_req, 0);
      chk("R10 final pointer", ptr_rd, base + 4 * 5);

      base = 32'h0000_2000 - 4;
      preload(base);
      send(1'b1, 32'hFFFF_FF01);
      ack_delay = 0;
      for (int i = 0; i < 8; i++) begin
         store_word(32'h2000 + 4 * i, 32'h0C00_0000 ^ (32'h11 * i));
      end
      send(1'b1, 32'h2);
      send(1'b0, 32'h0);
      wait_idle_bus();
      repeat (2) @(negedge clk);
      chk("R10 second run pointer", ptr_rd, base + 4 * 8);
      chk("R4 all writes seen", writes_seen, 13);
      chk("R6 no leftover writes", exp_addr_q.size(), 0);
      chk("R8 err still set", err_sticky, 1);

      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset clears err", err_sticky, 0);
      chk("R1 reset clears ptr", ptr_rd, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule